// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a 32-bit count of seconds and raises an interrupt when that count equals a programmed alarm value. A built-in prescaler divides the system clock down to a once-per-second enable. On each enable the count advances by one and wraps modulo 2^32. Software talks to the block through a plain word-addressed register port inside a 4 KB window. Reads are combinational from the address. Writes take effect on the rising clock edge where `wr_en` is high.

Software can set the count directly, program the alarm value, mask the interrupt, and acknowledge a pending alarm. The alarm is an equality compare, not a countdown. It is checked whenever the count advances and whenever software rewrites either the count or the alarm value. So a write that leaves the two equal flags the alarm on that same edge. The top eight words of the window form a read-only identification area.

The reset `rst_n` is asynchronous and active low. Its deassertion is expected to be synchronous to `clk`.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset the count, alarm value, last loaded value, mask and pending flag are all 0, and `irq` is 0.
- R2: The prescaler asserts its enable on every `CLK_HZ`-th rising edge after reset. The count increments on each such edge and wraps from 0xFFFFFFFF to 0. Word 0x00 reads the live count.
- R3: Writing word 0x08 sets the count to the written value on that edge, even if the enable is high in the same cycle. Reading 0x08 returns the last value written there.
- R4: Word 0x04 holds the alarm value. It is fully readable and writable.
- R5: Word 0x10 is the interrupt mask. Only bit 0 is kept, and the other bits read as 0.
- R6: Word 0x14 bit 0 is the pending flag. It is set on the edge where the count advances to a value equal to the alarm value.
- R7: A write to 0x04 or 0x08 that leaves the count equal to the alarm value sets the pending flag on that edge.
- R8: Word 0x18 reads the pending flag AND the mask in bit 0. `irq` carries the same value at all times.
- R9: Any write to 0x1C clears the pending flag on that edge, and `irq` falls with it. A new match on the same edge wins over the clear. Reading 0x1C returns 0.
- R10: Word 0x0C always reads 1, and writes to it have no effect.
- R11: The words at 0xFE0 through 0xFFC read, in address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, each zero-extended.
- R12: Writes to 0x00, 0x14 and 0x18 have no effect. Any address that is not word-aligned, or not listed above, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 12 | Byte address within the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Masked alarm interrupt |

## Verification
Read data is combinational, so any state change is visible at `rdata` and `irq` half a cycle after the edge that caused it. This holds for a load, an alarm write, a clear, a mask change and a prescaler enable. The bench drives stimulus on falling edges. It keeps an arithmetic model of the count, prescaler phase, alarm value and pending flag, which advances on rising edges. Every read is then compared on the following falling edge against that model. Because the model tracks the prescaler phase exactly, a count advancing into the alarm value in the same cycle as a write is predicted rather than avoided. A small divide ratio lets the bench sweep wrap-around, the whole address window and every register within a few thousand cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Word indices (byte offset / 4) of the register window.
  localparam int unsigned WI_COUNT = 0;
  localparam int unsigned WI_ALARM = 1;
  localparam int unsigned WI_LOAD  = 2;
  localparam int unsigned WI_CTRL  = 3;
  localparam int unsigned WI_MASK  = 4;
  localparam int unsigned WI_RAW   = 5;
  localparam int unsigned WI_MSKD  = 6;
  localparam int unsigned WI_ACK   = 7;
  localparam int unsigned ID_WORDS = 8;

  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h31;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h14;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (CLK_HZ <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(CLK_HZ);
      localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);
      logic [PW-1:0] phase_q, phase_d;

      always_comb begin
        tick_o  = (phase_q == LAST);
        phase_d = tick_o ? '0 : phase_q + PW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ld_we,
  input  logic          al_we,
  input  logic          ack_we,
  input  logic [DW-1:0] wval,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] alarm_o,
  output logic          pend_o
);
  logic [DW-1:0] cnt_q, cnt_d, alarm_q, alarm_d;
  logic          pend_q, pend_d;
  logic          cnt_en, alarm_en, eval, hit;

  always_comb begin
    cnt_en   = tick | ld_we;
    alarm_en = al_we;
    cnt_d    = ld_we ? wval : cnt_q + {{(DW-1){1'b0}}, tick};
    alarm_d  = al_we ? wval : alarm_q;
    eval     = tick | ld_we | al_we;
    hit      = eval && (cnt_d == alarm_d);
    if (hit)         pend_d = 1'b1;
    else if (ack_we) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (alarm_en) alarm_q <= alarm_d;
      pend_q <= pend_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign alarm_o = alarm_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] alarm,
  input  logic          pend,
  output logic          ld_we,
  output logic          al_we,
  output logic          ack_we,
  output logic          mask_o,
  output logic [DW-1:0] rdata
);
  import rtc_pkg::*;
  localparam int unsigned WW = AW - 2;
  localparam int unsigned ID_BASE = (1 << WW) - ID_WORDS;

  logic [WW-1:0] word;
  logic          aligned, in_id, mask_we, mask_q, mask_d;
  logic [DW-1:0] last_ld_q;

  always_comb begin
    word    = addr[AW-1:2];
    aligned = (addr[1:0] == 2'b00);
    in_id   = aligned && (word >= WW'(ID_BASE));
    ld_we   = wr_en && aligned && (word == WW'(WI_LOAD));
    al_we   = wr_en && aligned && (word == WW'(WI_ALARM));
    mask_we = wr_en && aligned && (word == WW'(WI_MASK));
    ack_we  = wr_en && aligned && (word == WW'(WI_ACK));
    mask_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= 1'b0;
      last_ld_q <= '0;
    end else begin
      if (mask_we) mask_q    <= mask_d;
      if (ld_we)   last_ld_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_id) begin
      rdata = {{(DW-8){1'b0}}, ident_byte(word[2:0])};
    end else if (aligned) begin
      case (word)
        WW'(WI_COUNT): rdata = cnt;
        WW'(WI_ALARM): rdata = alarm;
        WW'(WI_LOAD):  rdata = last_ld_q;
        WW'(WI_CTRL):  rdata = {{(DW-1){1'b0}}, 1'b1};
        WW'(WI_MASK):  rdata = {{(DW-1){1'b0}}, mask_q};
        WW'(WI_RAW):   rdata = {{(DW-1){1'b0}}, pend};
        WW'(WI_MSKD):  rdata = {{(DW-1){1'b0}}, pend & mask_q};
        default:       rdata = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic          tick, ld_we, al_we, ack_we, mask, pend;
  logic [DW-1:0] cnt, alarm;

  rtc_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  rtc_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ld_we(ld_we), .al_we(al_we), .ack_we(ack_we), .wval(wdata),
    .cnt_o(cnt), .alarm_o(alarm), .pend_o(pend)
  );

  rtc_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .alarm(alarm), .pend(pend),
    .ld_we(ld_we), .al_we(al_we), .ack_we(ack_we),
    .mask_o(mask), .rdata(rdata)
  );

  assign irq = pend & mask;
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic          tick,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] alarm,
  input logic          pend
);
  logic is_load, is_ack, adv_hit, undecoded;
  always_comb begin
    is_load   = wr_en && addr == AW'(12'h008);
    is_ack    = wr_en && addr == AW'(12'h01C);
    adv_hit   = tick && (cnt + {{(DW-1){1'b0}}, 1'b1} == alarm);
    undecoded = addr >= AW'(12'h020) && addr < AW'(12'hFE0);
  end

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> cnt == $past(wdata));
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !is_load) |=> cnt == $past(cnt) + {{(DW-1){1'b0}}, 1'b1});
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !is_load) |=> $stable(cnt));
  p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_hit && !wr_en) |=> pend);
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ack && !adv_hit) |=> (!pend && !irq));
  p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(12'h018)) |-> rdata == {{(DW-1){1'b0}}, irq});
  p_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(12'h00C)) |-> rdata == {{(DW-1){1'b0}}, 1'b1});
  p_hole_r12: assert property (@(posedge clk) disable iff (!rst_n)
    undecoded |-> rdata == '0);
endmodule

bind rtc_alarm_top rtc_alarm_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .tick(tick), .cnt(cnt), .alarm(alarm),
  .pend(pend)
);

// File: tb/rtc_alarm_top_bench.sv
`timescale 1ns/1ps
module rtc_alarm_top_bench;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_top #(.CLK_HZ(DIV)) u_rtc_alarm_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Arithmetic model built from the requirements.
  int unsigned m_pre;
  logic [31:0] m_cnt, m_al, m_ld;
  logic        m_im, m_is;

  always @(posedge clk) begin : model
    logic        t, ev, ack;
    logic [31:0] nc, na;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_al = 0; m_ld = 0; m_im = 0; m_is = 0;
    end else begin
      t   = (m_pre == DIV - 1);
      m_pre = t ? 0 : m_pre + 1;
      nc  = m_cnt + (t ? 32'd1 : 32'd0);
      na  = m_al;
      ev  = t;
      ack = 1'b0;
      if (wr_en && addr[1:0] == 2'b00) begin
        case (addr[11:2])
          10'd1: begin na = wdata; ev = 1'b1; end
          10'd2: begin nc = wdata; m_ld = wdata; ev = 1'b1; end
          10'd4: m_im = wdata[0];
          10'd7: ack = 1'b1;
          default: ;
        endcase
      end
      m_cnt = nc;
      m_al  = na;
      if (ev && nc == na) m_is = 1'b1;
      else if (ack)       m_is = 1'b0;
    end
  end

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a >= 12'hFE0) begin
      case (a[4:2])
        3'd0: return 32'h31;  3'd1: return 32'h10;
        3'd2: return 32'h14;  3'd3: return 32'h00;
        3'd4: return 32'h0D;  3'd5: return 32'hF0;
        3'd6: return 32'h05;  default: return 32'hB1;
      endcase
    end
    case (a)
      12'h000: return m_cnt;
      12'h004: return m_al;
      12'h008: return m_ld;
      12'h00C: return 32'h1;
      12'h010: return {31'b0, m_im};
      12'h014: return {31'b0, m_is};
      12'h018: return {31'b0, m_is & m_im};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (a[1:0] != 2'b00) return "R12";
    if (a >= 12'hFE0) return "R11";
    case (a)
      12'h000: return "R2";
      12'h004: return "R4";
      12'h008: return "R3";
      12'h00C: return "R10";
      12'h010: return "R5";
      12'h014: return "R6";
      12'h018: return "R8";
      12'h01C: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    #1;
    check(tag, rdata, exp_read(a));
    check("R8 irq", {31'b0, irq}, {31'b0, m_is & m_im});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;

    // R1: reset values across decoded words (count compared to model).
    for (int a = 0; a < 'h40; a += 4) rd(12'(a), "R1");

    // R2: count advances every DIV cycles.
    for (int i = 0; i < 12; i++) rd(12'h000, "R2");

    // R6: alarm reached by advancing, mask clear so irq stays low.
    wr(12'h004, m_cnt + 32'd3);
    for (int i = 0; i < 16; i++) rd(12'h014, "R6");

    // R5: only bit 0 of the mask is kept.
    wr(12'h010, 32'hFFFF_FFFE);
    rd(12'h010, "R5");
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, "R5");
    rd(12'h018, "R8");

    // R9: clear, and clear register reads 0.
    wr(12'h01C, 32'h0);
    rd(12'h014, "R9");
    rd(12'h01C, "R9");

    // R7: load equal to alarm value flags at once.
    wr(12'h008, m_al);
    rd(12'h014, "R7");
    rd(12'h018, "R7");
    wr(12'h01C, 32'h1);
    rd(12'h014, "R9");
    // R7: alarm write equal to the current count.
    wr(12'h004, m_cnt);
    rd(12'h014, "R7");
    wr(12'h01C, 32'h0);

    // R2 wrap and R6 across wrap.
    wr(12'h008, 32'hFFFF_FFFD);
    wr(12'h004, 32'h0000_0001);
    for (int i = 0; i < 24; i++) begin
      rd(12'h000, "R2");
      rd(12'h014, "R6");
    end

    // R10 / R12: writes that must do nothing.
    wr(12'h00C, 32'h0);
    rd(12'h00C, "R10");
    wr(12'h000, 32'h1234_5678);
    rd(12'h000, "R12");
    wr(12'h014, 32'h0);
    rd(12'h014, "R12");
    wr(12'h018, 32'h0);
    rd(12'h018, "R12");
    wr(12'h00A, 32'hDEAD_BEEF);
    rd(12'h008, "R12");
    rd(12'h00A, "R12");
    wr(12'h011, 32'h0);
    rd(12'h010, "R12");

    // R3 / R4 readback.
    wr(12'h004, 32'hA5A5_5A5A);
    rd(12'h004, "R4");
    wr(12'h008, 32'h0000_1000);
    rd(12'h008, "R3");
    rd(12'h000, "R3");

    // Sweep the whole window, R11 and R12 among others.
    for (int a = 0; a < 'h1000; a += 4) rd(12'(a), tag_of(12'(a)));
    for (int a = 'hFE1; a < 'h1000; a += 5) rd(12'(a), "R12");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule